// File: doc/BRIEF.md
# Real-Time Clock Update and Interrupt Core

This block is the timekeeping heart of a real-time clock. It holds seconds, minutes and hours together with a matching alarm byte for each. Four control and status locations sit beside them in one small addressed register file. A once-per-second tick starts an update window with a visible busy bit. At the end of that window the time advances by one second, either in binary or in BCD, and in either 12-hour or 24-hour form.

Three event flags record what happened: a periodic tick, an alarm match and the end of an update. Each flag has its own enable bit. The enabled flags combine into one active-low interrupt line, and a read of the flag location clears all of them. Software can freeze updates to set the time. A power-sense input tells software whether the stored time can be trusted.

Register offsets: 0 seconds, 1 seconds alarm, 2 minutes, 3 minutes alarm, 4 hours, 5 hours alarm, 6 control A, 7 control B, 8 flags, 9 status.

Top module: `rtc_core`

## Requirements
- R1: Each committed update adds one second. Seconds roll from 59 to 0 and carry into minutes. Minutes roll from 59 to 0 and carry into hours. Control B bit 2 = 1 selects plain binary coding; bit 2 = 0 selects packed BCD (59 seconds is 3Bh in binary and 59h in BCD). The seconds byte changes only on a commit or a write to offset 0.
- R2: With control B bit 1 = 0 (12-hour form), hour bits 6:0 run 1 to 12 and hour bit 7 = 1 marks PM. Going from 11 to 12 inverts bit 7. Going from 12 to 1 keeps bit 7.
- R3: With control B bit 1 = 1 (24-hour form), hours run 0 to 23 and wrap from 23 to 0.
- R4: A `sec_tick` seen while no update is pending sets control A bit 7 (busy) on the next cycle. Busy stays high for UPD_DELAY cycles. The time bytes keep their old values until busy falls, and the advanced time appears on that same edge.
- R5: Control B bit 7 (hold) = 1 ignores ticks, and a write that sets it cancels a pending update without changing the time. Any write with bit 7 = 1 also forces bit 4 (update-ended enable) to 0.
- R6: The flags location reads {IRQF, PF, AF, UF, 0000} in bits 7 to 0. PF sets on `per_tick` whatever its enable is. UF sets at every commit. AF sets at a commit whose new seconds, minutes and hours all equal the three alarm bytes.
- R7: IRQF = PF·B6 + AF·B5 + UF·B4. `irq_n` is low exactly when IRQF is 1.
- R8: A read of the flags location clears PF, AF and UF (a set in the same cycle wins). A write to it changes nothing. Its bits 3:0 always read 0.
- R9: Reset clears the three flags, the pending update and control B bits 5, 4 and 3. It leaves control B bits 7, 6, 2 and 1 as they were.
- R10: The status location reads {valid, 0000000}. `valid` is 0 while `pwr_good` is low. A read of the status location while `pwr_good` is high sets it from the next cycle on.
- R11: Control A bits 6:0 are plain storage. Its bit 7 reflects only the busy state, and writes do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| per_tick | input | 1 | One-cycle pulse from the selected periodic tap |
| pwr_good | input | 1 | Power sense, high when backup supply is valid |
| we | input | 1 | Register write strobe |
| re | input | 1 | Register read strobe (read side effects) |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The checker watches several rules on every cycle. A tick while the block is idle starts the busy window. The hold bit and a pending update never coexist. The update-ended flag only rises after a commit. The seconds byte moves only on a commit or its own write. A clean read of the flags location releases the interrupt. The arithmetic of the time advance cannot be seen by these properties: the 12-hour PM toggling, the 23-to-0 wrap, BCD digit carries and the alarm match all need the bench's sweeps over every hour and every second in all four coding modes. The same holds for the exact busy window length, the cancel-by-hold case and what survives a reset.

// File: rtl/rtc_pkg.sv
// Shared offsets, bit positions, time record and BCD/binary step helper.
package rtc_pkg;
    localparam int AW = 4;
    localparam int DW = 8;

    localparam logic [AW-1:0] A_SEC    = 4'd0;
    localparam logic [AW-1:0] A_SEC_AL = 4'd1;
    localparam logic [AW-1:0] A_MIN    = 4'd2;
    localparam logic [AW-1:0] A_MIN_AL = 4'd3;
    localparam logic [AW-1:0] A_HR     = 4'd4;
    localparam logic [AW-1:0] A_HR_AL  = 4'd5;
    localparam logic [AW-1:0] A_CTLA   = 4'd6;
    localparam logic [AW-1:0] A_CTLB   = 4'd7;
    localparam logic [AW-1:0] A_FLAG   = 4'd8;
    localparam logic [AW-1:0] A_STAT   = 4'd9;

    localparam int B_HOLD = 7;
    localparam int B_PIE  = 6;
    localparam int B_AIE  = 5;
    localparam int B_UIE  = 4;
    localparam int B_SQWE = 3;
    localparam int B_BIN  = 2;
    localparam int B_H24  = 1;

    localparam int NFLAG = 3;   // index 0 update-ended, 1 alarm, 2 periodic

    typedef struct packed {
        logic [DW-1:0] hr;
        logic [DW-1:0] min;
        logic [DW-1:0] sec;
    } rtc_time_t;

    // Add one to a byte in binary or packed BCD (caller handles wrap).
    function automatic logic [DW-1:0] step_val(input logic [DW-1:0] v, input logic bin);
        if (!bin && v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return v + 8'd1;
    endfunction
endpackage

// File: rtl/rtc_time_adv.sv
// Combinational one-second advance of seconds/minutes/hours.
// Assumes the present time is a legal value for the selected coding and form.
module rtc_time_adv
    import rtc_pkg::*;
(
    input  rtc_time_t cur,
    input  logic      bin_mode,
    input  logic      h24_mode,
    output rtc_time_t nxt
);
    logic [DW-1:0] lim59, lim23, c11, c12, h_inc;
    logic          sec_wrap, min_wrap;

    // Next-time computation with carries (R1, R2, R3).
    always_comb begin
        lim59    = bin_mode ? 8'd59 : 8'h59;
        lim23    = bin_mode ? 8'd23 : 8'h23;
        c11      = bin_mode ? 8'd11 : 8'h11;
        c12      = bin_mode ? 8'd12 : 8'h12;
        sec_wrap = (cur.sec == lim59);
        min_wrap = (cur.min == lim59);
        h_inc    = step_val({1'b0, cur.hr[6:0]}, bin_mode);
        nxt      = cur;
        nxt.sec  = sec_wrap ? 8'd0 : step_val(cur.sec, bin_mode);
        if (sec_wrap) begin
            nxt.min = min_wrap ? 8'd0 : step_val(cur.min, bin_mode);
            if (min_wrap) begin
                if (h24_mode)
                    nxt.hr = (cur.hr == lim23) ? 8'd0 : step_val(cur.hr, bin_mode);
                else if (cur.hr[6:0] == c12[6:0])
                    nxt.hr = {cur.hr[7], 7'd1};
                else if (cur.hr[6:0] == c11[6:0])
                    nxt.hr = {~cur.hr[7], c12[6:0]};
                else
                    nxt.hr = {cur.hr[7], h_inc[6:0]};
            end
        end
    end
endmodule

// File: rtl/rtc_upd_seq.sv
// Update window sequencer: a tick opens a busy window of UPD_DELAY cycles,
// whose last edge is the commit. Assumes UPD_DELAY >= 1; hold cancels.
module rtc_upd_seq #(
    parameter int UPD_DELAY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick,
    input  logic hold,
    output logic uip,
    output logic commit
);
    localparam int CW = $clog2(UPD_DELAY + 1);
    logic [CW-1:0] cnt_q;
    logic          uip_q;

    // Busy flag and countdown (R4, R5).
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            uip_q <= 1'b0;
            cnt_q <= '0;
        end else if (uip_q) begin
            if (cnt_q == '0) uip_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end else if (sec_tick) begin
            uip_q <= 1'b1;
            cnt_q <= CW'(UPD_DELAY - 1);
        end
    end

    assign uip    = uip_q;
    assign commit = uip_q && (cnt_q == '0) && !hold;
endmodule

// File: rtl/rtc_irq.sv
// Event flags with read-to-clear and the enabled-OR interrupt equation.
// A set in the same cycle as a clear wins.
module rtc_irq
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_ev,
    input  logic [NFLAG-1:0] en,
    input  logic             clr,
    output logic [NFLAG-1:0] flags,
    output logic             irqf
);
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        // One sticky flag per event source (R6, R8, R9).
        always_ff @(posedge clk) begin
            if (!rst_n) flags[i] <= 1'b0;
            else        flags[i] <= set_ev[i] | (flags[i] & ~clr);
        end
    end

    assign irqf = |(flags & en);   // R7
endmodule

// File: rtl/rtc_core.sv
// Top: register file, update sequencer, time advance and interrupt flags.
// Time and alarm bytes are not reset; software initialises them under hold.
module rtc_core
    import rtc_pkg::*;
#(
    parameter int UPD_DELAY = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sec_tick,
    input  logic          per_tick,
    input  logic          pwr_good,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          irq_n
);
    rtc_time_t        time_q, alarm_q, time_nxt;
    logic [6:0]       ctla_q;
    logic [DW-1:0]    ctlb_q;
    logic             vrt_q;
    logic             uip_w, commit_w, hold_w, irqf_w;
    logic [NFLAG-1:0] flags_w, set_w, en_w;

    assign hold_w = ctlb_q[B_HOLD] | (we && addr == A_CTLB && wdata[B_HOLD]);

    rtc_upd_seq #(.UPD_DELAY(UPD_DELAY)) seq_i (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .hold(hold_w),
        .uip(uip_w), .commit(commit_w)
    );

    rtc_time_adv adv_i (
        .cur(time_q), .bin_mode(ctlb_q[B_BIN]), .h24_mode(ctlb_q[B_H24]), .nxt(time_nxt)
    );

    assign set_w = {per_tick, commit_w && (time_nxt == alarm_q), commit_w};
    assign en_w  = {ctlb_q[B_PIE], ctlb_q[B_AIE], ctlb_q[B_UIE]};

    rtc_irq irq_i (
        .clk(clk), .rst_n(rst_n), .set_ev(set_w), .en(en_w),
        .clr(re && addr == A_FLAG), .flags(flags_w), .irqf(irqf_w)
    );

    // Time bytes: commit has priority over a software write (R1, R4).
    always_ff @(posedge clk) begin
        if (commit_w)                  time_q     <= time_nxt;
        else if (we && addr == A_SEC)  time_q.sec <= wdata;
        else if (we && addr == A_MIN)  time_q.min <= wdata;
        else if (we && addr == A_HR)   time_q.hr  <= wdata;
    end

    // Alarm bytes and control A storage (R6, R11).
    always_ff @(posedge clk) begin
        if (we && addr == A_SEC_AL) alarm_q.sec <= wdata;
        if (we && addr == A_MIN_AL) alarm_q.min <= wdata;
        if (we && addr == A_HR_AL)  alarm_q.hr  <= wdata;
        if (we && addr == A_CTLA)   ctla_q      <= wdata[6:0];
    end

    // Control B: reset clears only enables; hold forces update-ended enable off (R5, R9).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctlb_q[B_AIE]  <= 1'b0;
            ctlb_q[B_UIE]  <= 1'b0;
            ctlb_q[B_SQWE] <= 1'b0;
        end else if (we && addr == A_CTLB) begin
            ctlb_q        <= wdata;
            ctlb_q[B_UIE] <= wdata[B_UIE] & ~wdata[B_HOLD];
        end
    end

    // Valid-time bit follows power sense, set by a status read (R10).
    always_ff @(posedge clk) begin
        if (!pwr_good)                 vrt_q <= 1'b0;
        else if (re && addr == A_STAT) vrt_q <= 1'b1;
    end

    // Read mux.
    always_comb begin
        case (addr)
            A_SEC:    rdata = time_q.sec;
            A_SEC_AL: rdata = alarm_q.sec;
            A_MIN:    rdata = time_q.min;
            A_MIN_AL: rdata = alarm_q.min;
            A_HR:     rdata = time_q.hr;
            A_HR_AL:  rdata = alarm_q.hr;
            A_CTLA:   rdata = {uip_w, ctla_q};
            A_CTLB:   rdata = ctlb_q;
            A_FLAG:   rdata = {irqf_w, flags_w[2], flags_w[1], flags_w[0], 4'b0000};
            A_STAT:   rdata = {vrt_q, 7'b0};
            default:  rdata = '0;
        endcase
    end

    assign irq_n = ~irqf_w;
endmodule

// File: rtl/rtc_core_chk.sv
// Cycle-level rules for rtc_core, attached by bind.
module rtc_core_chk
    import rtc_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          sec_tick,
    input logic          per_tick,
    input logic          we,
    input logic          re,
    input logic [AW-1:0] addr,
    input logic          uip,
    input logic          commit,
    input logic          hold,
    input logic          hold_bit,
    input logic          uf,
    input logic [DW-1:0] sec,
    input logic          irq_n
);
    // R4
    tick_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !uip && !hold) |=> uip);

    // R5
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_bit |-> !uip);

    // R6
    uf_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uf) |-> $past(commit));

    // R1
    sec_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sec) |-> $past(commit || (we && addr == A_SEC)));

    // R8
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (re && addr == A_FLAG && !per_tick && !commit) |=> irq_n);
endmodule

bind rtc_core rtc_core_chk chk_i (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .per_tick(per_tick),
    .we(we), .re(re), .addr(addr), .uip(uip_w), .commit(commit_w),
    .hold(hold_w), .hold_bit(ctlb_q[7]), .uf(flags_w[0]), .sec(time_q.sec),
    .irq_n(irq_n)
);

// File: tb/rtc_core_tb_top.sv
// Sweeps every hour and every second in all four coding modes, plus
// busy window, hold, flags, interrupt, reset and status scenarios.
module rtc_core_tb_top;
    localparam int UPD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0, per_tick = 1'b0, pwr_good = 1'b0;
    logic       we = 1'b0, re = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_n;
    int         checks = 0, errors = 0;
    logic [7:0] v;

    always #5 clk = ~clk;

    rtc_core #(.UPD_DELAY(UPD)) dut_i (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .per_tick(per_tick),
        .pwr_good(pwr_good), .we(we), .re(re), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_n(irq_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); re = 1'b1; addr = a; #1 d = rdata;
        @(negedge clk); re = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
    endtask

    task automatic full_tick();
        pulse_tick();
        repeat (UPD + 2) @(negedge clk);
    endtask

    task automatic pulse_per();
        @(negedge clk); per_tick = 1'b1;
        @(negedge clk); per_tick = 1'b0;
    endtask

    function automatic logic [7:0] enc(input int x, input bit bin);
        return bin ? 8'(x) : 8'(((x / 10) << 4) | (x % 10));
    endfunction

    function automatic logic [7:0] hr_enc(input int h, input bit bin, input bit h24);
        int x;
        if (h24) return enc(h, bin);
        x = h % 12;
        if (x == 0) x = 12;
        return (h >= 12 ? 8'h80 : 8'h00) | enc(x, bin);
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        #1 chk("R9 irq_n after reset", {7'b0, irq_n}, 8'h01);
        rd(4'd8, v); chk("R9 flags after reset", v, 8'h00);
        rd(4'd6, v); chk("R4 busy idle after reset", v & 8'h80, 8'h00);

        // R11 control A storage, bit 7 read-only
        wr(4'd6, 8'hFF); rd(4'd6, v); chk("R11 ctlA write ff", v, 8'h7F);
        wr(4'd6, 8'h25); rd(4'd6, v); chk("R11 ctlA write 25", v, 8'h25);

        // R2 R3 R1 hour sweep over all modes
        for (int m = 0; m < 4; m++) begin
            bit bin, h24;
            bin = m[0]; h24 = m[1];
            wr(4'd7, {5'b0, bin, h24, 1'b0});
            for (int h = 0; h < 24; h++) begin
                wr(4'd0, enc(59, bin)); wr(4'd2, enc(59, bin)); wr(4'd4, hr_enc(h, bin, h24));
                full_tick();
                rd(4'd4, v);
                chk(h24 ? "R3 hour wrap/step" : "R2 12h hour step", v, hr_enc((h + 1) % 24, bin, h24));
                rd(4'd2, v); chk("R1 minute wrap", v, 8'h00);
                rd(4'd0, v); chk("R1 second wrap", v, 8'h00);
            end
            // R1 seconds sweep
            for (int s = 0; s < 60; s++) begin
                wr(4'd0, enc(s, bin)); wr(4'd2, enc(7, bin)); wr(4'd4, hr_enc(5, bin, h24));
                full_tick();
                rd(4'd0, v); chk("R1 second step", v, enc((s + 1) % 60, bin));
                rd(4'd2, v); chk("R1 minute carry", v, enc(s == 59 ? 8 : 7, bin));
            end
        end

        // R4 busy window and late commit
        wr(4'd7, 8'h02);
        wr(4'd0, 8'h10);
        pulse_tick();
        rd(4'd6, v); chk("R4 busy during window", v & 8'h80, 8'h80);
        rd(4'd0, v); chk("R4 time held in window", v, 8'h10);
        repeat (UPD) @(negedge clk);
        rd(4'd6, v); chk("R4 busy cleared", v & 8'h80, 8'h00);
        rd(4'd0, v); chk("R4 time committed", v, 8'h11);

        // R5 hold: clears update-ended enable, ignores ticks, cancels pending
        wr(4'd7, 8'h92); rd(4'd7, v); chk("R5 hold clears UIE", v, 8'h82);
        full_tick();
        rd(4'd0, v); chk("R5 tick ignored under hold", v, 8'h11);
        rd(4'd6, v); chk("R5 no busy under hold", v & 8'h80, 8'h00);
        wr(4'd7, 8'h02);
        rd(4'd8, v);
        pulse_tick();
        wr(4'd7, 8'h82);
        repeat (UPD + 2) @(negedge clk);
        rd(4'd0, v); chk("R5 pending update cancelled", v, 8'h11);
        rd(4'd8, v); chk("R5 no update-ended after cancel", v, 8'h00);
        wr(4'd7, 8'h02);

        // R6 R8 flags
        rd(4'd8, v);
        pulse_per();
        #1 chk("R7 no irq with PIE off", {7'b0, irq_n}, 8'h01);
        rd(4'd8, v); chk("R6 PF without enable", v, 8'h40);
        rd(4'd8, v); chk("R8 read clears flags", v, 8'h00);
        pulse_per();
        wr(4'd8, 8'hFF); rd(4'd8, v); chk("R8 write ignored, low bits zero", v, 8'h40);
        full_tick();
        rd(4'd8, v); chk("R6 UF after update", v, 8'h10);
        wr(4'd1, 8'h04); wr(4'd3, 8'h02); wr(4'd5, 8'h01);
        wr(4'd0, 8'h03); wr(4'd2, 8'h02); wr(4'd4, 8'h01);
        full_tick();
        rd(4'd8, v); chk("R6 AF on match", v, 8'h30);
        wr(4'd0, 8'h05);
        full_tick();
        rd(4'd8, v); chk("R6 no AF on mismatch", v, 8'h10);

        // R7 interrupt equation
        wr(4'd7, 8'h22);
        wr(4'd0, 8'h03); wr(4'd2, 8'h02); wr(4'd4, 8'h01);
        full_tick();
        #1 chk("R7 irq on AF with AIE", {7'b0, irq_n}, 8'h00);
        rd(4'd8, v); chk("R7 IRQF visible", v, 8'hB0);
        #1 chk("R8 irq released by read", {7'b0, irq_n}, 8'h01);
        wr(4'd7, 8'h42);
        pulse_per();
        #1 chk("R7 irq on PF with PIE", {7'b0, irq_n}, 8'h00);
        rd(4'd8, v); chk("R7 flags PF IRQF", v, 8'hC0);
        wr(4'd7, 8'h12);
        full_tick();
        #1 chk("R7 irq on UF with UIE", {7'b0, irq_n}, 8'h00);
        rd(4'd8, v);

        // R9 reset keeps mode bits, clears enables and flags
        wr(4'd7, 8'h7E);
        pulse_per();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        rd(4'd7, v); chk("R9 reset clears AIE UIE SQWE", v, 8'h46);
        rd(4'd8, v); chk("R9 reset clears flags", v, 8'h00);
        wr(4'd7, 8'h86);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        rd(4'd7, v); chk("R9 reset keeps hold", v, 8'h86);
        wr(4'd7, 8'h02);

        // R10 valid-time status
        rd(4'd9, v); chk("R10 invalid without power", v, 8'h00);
        pwr_good = 1'b1;
        rd(4'd9, v); chk("R10 first read shows old", v, 8'h00);
        rd(4'd9, v); chk("R10 set after read", v, 8'h80);
        pwr_good = 1'b0;
        @(negedge clk);
        rd(4'd9, v); chk("R10 cleared on power loss", v, 8'h00);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule